// File: doc/BRIEF.md
# Multiply-Accumulate Execution Unit

This unit is the multiply and accumulate stage of a 64-bit integer pipeline. Each accepted request carries a decoded 32-bit instruction word and the values of its two source registers. The unit multiplies the low 32 bits of the two sources, either as signed or as unsigned numbers. It then folds the product into a 64-bit accumulator, and it hands back one 32-bit half of the new accumulator, sign-extended to 64 bits, for the destination register.

The accumulator does not live in a register of its own. Its upper word is the low word of the HI register and its lower word is the low word of the LO register. Both registers are held inside the unit and shown at its ports. There are four ways to update the accumulator: load the product, load the negated product, add the product, or subtract the product. Every instruction word that does not decode as one of these is answered with an illegal flag and changes nothing.

The request side is a valid/ready handshake. Ready is high whenever the unit is out of reset, so a request can be accepted every cycle. Results appear registered in the cycle after acceptance.

Top module: `mulacc_unit`

## Requirements
- R1: While reset is asserted, HI, LO and every response output are zero and req_ready is low. From the first clock edge after reset is released, req_ready is high.
- R2: The accumulator is {HI[31:0], LO[31:0]}. An update writes its upper word to HI[31:0] and its lower word to LO[31:0]. HI[63:32] and LO[63:32] always hold copies of bit 31 of their register.
- R3: Only bits 31:0 of each source value take part in the multiply. Bits 63:32 of both sources have no effect.
- R4: Function code 6'b011001 (instruction bits 5:0) selects an unsigned multiply: a zero-extended 64-bit product.
- R5: Function code 6'b011000 selects a signed multiply: a 64-bit two's-complement product. Instruction bits 10:6 = 5'b00001 load the accumulator with the product.
- R6: Bits 10:6 = 5'b00011 load the accumulator with zero minus the product, modulo 2^64.
- R7: Bits 10:6 = 5'b00101 add the product to the accumulator.
- R8: Bits 10:6 = 5'b00111 subtract the product from the accumulator.
- R9: Instruction bit 9 = 1 (bits 10:6 = 01001, 01011, 01101 or 01111) returns the upper word of the new accumulator instead of the lower word. Either word reaches rsp_rd_data sign-extended from its bit 31.
- R10: A legal instruction needs primary opcode bits 31:26 = 6'b000000. Its response has rsp_wr_en = 1, rsp_illegal = 0 and rsp_rd_idx = instruction bits 15:11.
- R11: Any other opcode, function code or bits 10:6 value gives a response with rsp_illegal = 1, rsp_wr_en = 0, rsp_rd_idx = 0 and rsp_rd_data = 0. HI and LO are left unchanged.
- R12: rsp_valid is high in exactly the cycle after an accepted request. A request accepted in the very next cycle already sees the accumulator written by the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_insn | input | 32 | Instruction word |
| req_rs_val | input | 64 | First source value |
| req_rt_val | input | 64 | Second source value |
| rsp_valid | output | 1 | Response present |
| rsp_illegal | output | 1 | Instruction was not recognised |
| rsp_wr_en | output | 1 | Destination register is to be written |
| rsp_rd_idx | output | 5 | Destination register index |
| rsp_rd_data | output | 64 | Sign-extended accumulator half |
| acc_hi | output | 64 | HI register |
| acc_lo | output | 64 | LO register |

## Verification
Two things can happen in the same cycle: the HI/LO write-back of one instruction and the accumulator read of the next one. The bench provokes this by holding req_valid high over runs of accumulate and subtract requests, with no idle cycle between them. Each response is judged against a bench-side accumulator that is chained across the whole run, so a stale read of HI/LO changes the returned half and the next expected HI/LO value. Illegal words are placed inside such runs as well, and the following legal instruction must still build on the accumulator from before the illegal word.

// File: rtl/mulacc_pkg.sv
package mulacc_pkg;
  localparam int INSN_W = 32;

  localparam logic [5:0] OPC_REG   = 6'b000000;
  localparam logic [5:0] FN_SIGNED = 6'b011000;
  localparam logic [5:0] FN_UNSIGN = 6'b011001;

  // Accumulator update kinds (taken from instruction bits 8:7)
  typedef enum logic [1:0] {
    ACC_LOAD = 2'b00,
    ACC_NEG  = 2'b01,
    ACC_ADD  = 2'b10,
    ACC_SUB  = 2'b11
  } acc_kind_e;

  typedef struct packed {
    logic      legal;
    logic      is_signed;
    logic      take_high;
    acc_kind_e kind;
    logic [4:0] rd;
  } mac_dec_t;
endpackage

// File: rtl/mulacc_decode.sv
module mulacc_decode
  import mulacc_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output mac_dec_t          dec
);
  logic [5:0] opcode, funct;
  logic [4:0] sel;
  logic       opc_ok, fn_ok, sel_ok;
  logic       unused_fields;

  assign opcode = insn[31:26];
  assign funct  = insn[5:0];
  assign sel    = insn[10:6];
  // source register indices are resolved outside this unit
  assign unused_fields = ^insn[25:16];

  assign opc_ok = (opcode == OPC_REG);
  assign fn_ok  = (funct == FN_SIGNED) || (funct == FN_UNSIGN);
  // legal selector values: 0 h k k 1
  assign sel_ok = !sel[4] && sel[0];

  always_comb begin
    dec.legal     = opc_ok && fn_ok && sel_ok;
    dec.is_signed = (funct == FN_SIGNED);
    dec.take_high = sel[3];
    dec.kind      = acc_kind_e'(sel[2:1]);
    dec.rd        = insn[15:11];
  end
endmodule

// File: rtl/mulacc_datapath.sv
module mulacc_datapath
  import mulacc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN/2-1:0] src_a,
  input  logic [XLEN/2-1:0] src_b,
  input  logic [XLEN/2-1:0] hi_word,
  input  logic [XLEN/2-1:0] lo_word,
  input  mac_dec_t          dec,
  output logic [XLEN-1:0]   prod,
  output logic [XLEN-1:0]   acc_new,
  output logic [XLEN-1:0]   hi_next,
  output logic [XLEN-1:0]   lo_next,
  output logic [XLEN-1:0]   rd_next
);
  localparam int HALF = XLEN / 2;

  function automatic logic [XLEN-1:0] widen(input logic [HALF-1:0] v, input logic sgn);
    return {{HALF{sgn & v[HALF-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] sext_half(input logic [HALF-1:0] v);
    return {{HALF{v[HALF-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] fold(input acc_kind_e k,
                                           input logic [XLEN-1:0] acc,
                                           input logic [XLEN-1:0] p);
    case (k)
      ACC_LOAD: return p;
      ACC_NEG:  return '0 - p;
      ACC_ADD:  return acc + p;
      default:  return acc - p;
    endcase
  endfunction

  logic [XLEN-1:0] wa, wb, acc_cur;

  assign wa      = widen(src_a, dec.is_signed);
  assign wb      = widen(src_b, dec.is_signed);
  assign prod    = wa * wb;
  assign acc_cur = {hi_word, lo_word};
  assign acc_new = fold(dec.kind, acc_cur, prod);
  assign hi_next = sext_half(acc_new[XLEN-1:HALF]);
  assign lo_next = sext_half(acc_new[HALF-1:0]);
  assign rd_next = dec.take_high ? hi_next : lo_next;
endmodule

// File: rtl/mulacc_unit.sv
module mulacc_unit
  import mulacc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [INSN_W-1:0] req_insn,
  input  logic [XLEN-1:0]   req_rs_val,
  input  logic [XLEN-1:0]   req_rt_val,
  output logic              rsp_valid,
  output logic              rsp_illegal,
  output logic              rsp_wr_en,
  output logic [4:0]        rsp_rd_idx,
  output logic [XLEN-1:0]   rsp_rd_data,
  output logic [XLEN-1:0]   acc_hi,
  output logic [XLEN-1:0]   acc_lo
);
  localparam int HALF = XLEN / 2;

  mac_dec_t        dec;
  logic            accept, commit;
  logic [XLEN-1:0] prod, acc_new, hi_next, lo_next, rd_next;
  logic            unused_upper;

  assign unused_upper = ^{req_rs_val[XLEN-1:HALF], req_rt_val[XLEN-1:HALF],
                          acc_hi[XLEN-1:HALF], acc_lo[XLEN-1:HALF], prod, acc_new};

  assign accept = req_valid && req_ready;
  assign commit = accept && dec.legal;

  mulacc_decode u_dec (
    .insn (req_insn),
    .dec  (dec)
  );

  mulacc_datapath #(.XLEN(XLEN)) u_dp (
    .src_a   (req_rs_val[HALF-1:0]),
    .src_b   (req_rt_val[HALF-1:0]),
    .hi_word (acc_hi[HALF-1:0]),
    .lo_word (acc_lo[HALF-1:0]),
    .dec     (dec),
    .prod    (prod),
    .acc_new (acc_new),
    .hi_next (hi_next),
    .lo_next (lo_next),
    .rd_next (rd_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_ready   <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_illegal <= 1'b0;
      rsp_wr_en   <= 1'b0;
      rsp_rd_idx  <= '0;
      rsp_rd_data <= '0;
      acc_hi      <= '0;
      acc_lo      <= '0;
    end else begin
      req_ready   <= 1'b1;
      rsp_valid   <= accept;
      rsp_illegal <= accept && !dec.legal;
      rsp_wr_en   <= commit;
      rsp_rd_idx  <= commit ? dec.rd : '0;
      rsp_rd_data <= commit ? rd_next : '0;
      if (commit) begin
        acc_hi <= hi_next;
        acc_lo <= lo_next;
      end
    end
  end
endmodule

// File: rtl/mulacc_unit_chk.sv
module mulacc_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            accept,
  input logic            rsp_valid,
  input logic            rsp_illegal,
  input logic            rsp_wr_en,
  input logic [XLEN-1:0] rsp_rd_data,
  input logic [XLEN-1:0] acc_hi,
  input logic [XLEN-1:0] acc_lo
);
  localparam int HALF = XLEN / 2;

  assert_accept_answered_R12: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  assert_no_spurious_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !rsp_valid);

  assert_illegal_keeps_acc_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_illegal) |-> ($stable(acc_hi) && $stable(acc_lo) && !rsp_wr_en));

  assert_halves_sext_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_hi[XLEN-1:HALF] == {HALF{acc_hi[HALF-1]}}) &&
    (acc_lo[XLEN-1:HALF] == {HALF{acc_lo[HALF-1]}}));

  assert_rd_is_acc_half_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_wr_en |-> ((rsp_rd_data == {{HALF{acc_hi[HALF-1]}}, acc_hi[HALF-1:0]}) ||
                   (rsp_rd_data == {{HALF{acc_lo[HALF-1]}}, acc_lo[HALF-1:0]})));

  assert_write_only_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_wr_en |-> (rsp_valid && !rsp_illegal));
endmodule

bind mulacc_unit mulacc_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .accept      (accept),
  .rsp_valid   (rsp_valid),
  .rsp_illegal (rsp_illegal),
  .rsp_wr_en   (rsp_wr_en),
  .rsp_rd_data (rsp_rd_data),
  .acc_hi      (acc_hi),
  .acc_lo      (acc_lo)
);

// File: tb/mulacc_unit_test.sv
`timescale 1ns/1ps
module mulacc_unit_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [31:0] req_insn = '0;
  logic [63:0] req_rs_val = '0, req_rt_val = '0;
  logic        rsp_valid, rsp_illegal, rsp_wr_en;
  logic [4:0]  rsp_rd_idx;
  logic [63:0] rsp_rd_data, acc_hi, acc_lo;

  always #2 clk = ~clk;

  mulacc_unit uut (.*);

  typedef struct packed {
    logic        illegal;
    logic        wr;
    logic [4:0]  idx;
    logic [63:0] data;
    logic [63:0] hi;
    logic [63:0] lo;
  } exp_t;

  exp_t        q_exp[$];
  string       q_tag[$];
  bit   [63:0] m_acc = '0;
  int          n_tests = 0, n_fail = 0;
  bit          done = 0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(logic [5:0] opc, logic [4:0] sel, logic [5:0] fn, logic [4:0] rd);
    return {opc, 5'd3, 5'd4, rd, sel, fn};
  endfunction

  function automatic logic [63:0] sx(logic [31:0] w);
    return {{32{w[31]}}, w};
  endfunction

  // driver: one request per call, on the falling edge; pushes the expectation
  task automatic send(string tag, logic [31:0] insn, logic [63:0] a, logic [63:0] b);
    exp_t e;
    bit legal, sgn;
    bit [63:0] p;
    logic [4:0] s;
    @(negedge clk);
    req_valid = 1; req_insn = insn; req_rs_val = a; req_rt_val = b;
    s = insn[10:6];
    sgn = (insn[5:0] == 6'h18);
    legal = (insn[31:26] == 0) && (insn[5:0] == 6'h18 || insn[5:0] == 6'h19) &&
            (s inside {5'd1, 5'd3, 5'd5, 5'd7, 5'd9, 5'd11, 5'd13, 5'd15});
    if (sgn) begin
      int sa, sb;
      longint sp;
      sa = a[31:0]; sb = b[31:0];
      sp = longint'(sa) * longint'(sb);
      p = sp;
    end else begin
      bit [63:0] ua, ub;
      ua = {32'b0, a[31:0]}; ub = {32'b0, b[31:0]};
      p = ua * ub;
    end
    if (legal) begin
      bit [63:0] base;
      base = s[2] ? m_acc : 64'd0;
      m_acc = s[1] ? base - p : base + p;
      e.illegal = 0; e.wr = 1; e.idx = insn[15:11];
      e.data = s[3] ? sx(m_acc[63:32]) : sx(m_acc[31:0]);
    end else begin
      e.illegal = 1; e.wr = 0; e.idx = 0; e.data = 0;
    end
    e.hi = sx(m_acc[63:32]);
    e.lo = sx(m_acc[31:0]);
    q_exp.push_back(e);
    q_tag.push_back(tag);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    req_valid = 0;
    req_rs_val = 64'hDEAD_BEEF_0BAD_F00D;
    repeat (n - 1) @(negedge clk);
  endtask

  // monitor: compares every response against the head of the queue
  initial begin
    forever begin
      @(posedge clk); #1;
      if (rst_n && rsp_valid) begin
        if (q_exp.size() == 0) begin
          chk("R12", "unexpected response", 64'd1, 64'd0);
        end else begin
          exp_t e;
          string t;
          e = q_exp.pop_front();
          t = q_tag.pop_front();
          chk(t, "illegal", {63'd0, rsp_illegal}, {63'd0, e.illegal});
          chk(t, "wr_en", {63'd0, rsp_wr_en}, {63'd0, e.wr});
          chk(t, "rd_idx", {59'd0, rsp_rd_idx}, {59'd0, e.idx});
          chk(t, "rd_data", rsp_rd_data, e.data);
          chk({t, "/R2"}, "hi", acc_hi, e.hi);
          chk({t, "/R2"}, "lo", acc_lo, e.lo);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "ready in reset", {63'd0, req_ready}, 64'd0);
    chk("R1", "rsp_valid in reset", {63'd0, rsp_valid}, 64'd0);
    chk("R1", "hi in reset", acc_hi, 64'd0);
    chk("R1", "lo in reset", acc_lo, 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "ready after reset", {63'd0, req_ready}, 64'd1);

    // R5 + R3: signed load, garbage in upper source bits
    send("R5", mk(6'd0, 5'b00001, 6'h18, 5'd7), 64'hFFFF_0000_0000_0007, 64'h1234_5678_FFFF_FFFD);
    idle(2);
    send("R3", mk(6'd0, 5'b00001, 6'h18, 5'd8), 64'h0000_0001_8000_0000, 64'h0000_0000_8000_0000);
    // R9: high half, signed
    send("R9", mk(6'd0, 5'b01001, 6'h18, 5'd9), 64'h0000_0000_1234_5678, 64'h0000_0000_9ABC_DEF0);
    // R4: unsigned high half of max*max
    send("R4", mk(6'd0, 5'b01001, 6'h19, 5'd10), 64'hFFFF_FFFF, 64'hFFFF_FFFF);
    send("R4", mk(6'd0, 5'b00001, 6'h19, 5'd11), 64'h8000_0000, 64'h3);
    // R6: negated product, both signednesses
    send("R6", mk(6'd0, 5'b00011, 6'h18, 5'd12), 64'h5, 64'hFFFF_FFF9);
    send("R6", mk(6'd0, 5'b01011, 6'h19, 5'd13), 64'h10, 64'h20);
    idle(1);
    // R7 + R12: back-to-back accumulate chain
    send("R7", mk(6'd0, 5'b00001, 6'h18, 5'd1), 64'h7FFF_FFFF, 64'h7FFF_FFFF);
    send("R7", mk(6'd0, 5'b00101, 6'h18, 5'd2), 64'h7FFF_FFFF, 64'h7FFF_FFFF);
    send("R12", mk(6'd0, 5'b01101, 6'h19, 5'd3), 64'hFFFF_FFFF, 64'h2);
    send("R12", mk(6'd0, 5'b00101, 6'h18, 5'd4), 64'hFFFF_FFFF, 64'h1);
    // R8: subtract chain
    send("R8", mk(6'd0, 5'b00111, 6'h18, 5'd5), 64'h1234, 64'h5678);
    send("R8", mk(6'd0, 5'b01111, 6'h19, 5'd6), 64'hFFFF_FFFF, 64'hFFFF_FFFF);
    // R11: illegal words inside a run; accumulator must survive
    send("R11", mk(6'd1, 5'b00101, 6'h18, 5'd14), 64'h3, 64'h3);
    send("R11", mk(6'd0, 5'b00101, 6'h1A, 5'd15), 64'h3, 64'h3);
    send("R11", mk(6'd0, 5'b00000, 6'h18, 5'd16), 64'h3, 64'h3);
    send("R11", mk(6'd0, 5'b10101, 6'h18, 5'd17), 64'h3, 64'h3);
    send("R11", mk(6'd0, 5'b00100, 6'h19, 5'd18), 64'h3, 64'h3);
    send("R10", mk(6'd0, 5'b00101, 6'h18, 5'd31), 64'h3, 64'h3);
    send("R10", mk(6'd0, 5'b01111, 6'h18, 5'd0), 64'hFFFF_FFFF, 64'h8000_0000);
    idle(4);
    // R12: nothing left outstanding, no response while idle
    chk("R12", "queue drained", 64'(q_exp.size()), 64'd0);
    chk("R12", "idle rsp_valid", {63'd0, rsp_valid}, 64'd0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule